// File: doc/BRIEF.md
# Page-Buffered Write Controller for a Serial Memory

This block sits behind a two-wire bus slave and owns every write transaction to the storage array. After the slave has matched the device address with a write direction, it signals the start of a transaction. The controller then takes two address bytes, most significant first, and loads a shared word pointer. Each following data byte goes into a one-page holding buffer of `PAGE_BYTES` slots. The slot is picked by the low address bits, and those bits wrap inside the page.

Nothing reaches the array until a valid STOP closes the transaction. At that point the write-protect input is sampled. If it is low and at least one data byte is held, the block raises `busy_o` for a self-timed programming interval of `WRITE_CYCLES` clocks, so that the slave stops acknowledging its address. It then walks the page and writes every filled slot through a plain memory write port. A transaction that is aborted by a repeated START or by loss of the bus leaves the array untouched. A STOP that follows only the address bytes just moves the pointer, which is how a random read sets its position.

States:
- `PW_IDLE`: waits for `txn_begin_i`.
- `PW_ADDR_HI`: takes the first address byte.
- `PW_ADDR_LO`: takes the second address byte and loads the pointer.
- `PW_DATA`: fills the buffer.
- `PW_PROG`: the timed lockout.
- `PW_COMMIT`: writes one slot per clock.

Transitions:
- IDLE to ADDR_HI on a transaction start.
- ADDR_HI to ADDR_LO, and ADDR_LO to DATA, on a byte.
- ADDR_HI, ADDR_LO or DATA back to IDLE on an abort, or on a STOP that starts no programming.
- DATA to PROG on a STOP with data held and write protect low.
- PROG to COMMIT when the timer expires.
- COMMIT to IDLE after the last slot.

Top module: `eeprom_page_writer`

## Requirements
- R1: After `txn_begin_i`, the first accepted byte supplies address bits [ADDR_W-1:8], taken from its low ADDR_W-8 bits. The second supplies bits [7:0]. On the second byte `ptr_o` takes the assembled start address.
- R2: Data byte k of a transaction is held in slot (start[4:0] + k) mod PAGE_BYTES of the start page. A later byte that lands on an occupied slot replaces the earlier one.
- R3: Commit begins exactly WRITE_CYCLES clocks after the STOP edge and visits slots 0 to PAGE_BYTES-1 in ascending order, one per clock. `mem_we_o` is high only for filled slots, with `mem_addr_o` = page base + slot and `mem_wdata_o` = the held byte.
- R4: `busy_o` rises in the cycle after an accepted STOP and stays high for exactly WRITE_CYCLES + PAGE_BYTES cycles.
- R5: While `busy_o` is high, `txn_begin_i`, `byte_vld_i`, `stop_i` and `abort_i` have no effect on the buffer, the pointer or later array writes.
- R6: `wp_i` is sampled in the STOP cycle. If it is high, no array write and no busy period follow, and `ptr_o` keeps the start address.
- R7: `abort_i` during the address or data phase discards the held bytes and starts no busy period. A pointer already loaded by R1 is kept.
- R8: At the end of commit, `ptr_o` = page base + last slot written + 1, modulo 2^ADDR_W.
- R9: A STOP after both address bytes but before any data leaves the pointer at the start address and starts no busy period.
- R10: Reset leaves `busy_o` = 0, `mem_we_o` = 0 and `ptr_o` = 0.
- R11: A STOP or abort before the second address byte leaves `ptr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin_i | input | 1 | Write transaction start pulse from the slave |
| byte_vld_i | input | 1 | A received byte is present on `byte_i` |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | Valid STOP condition pulse |
| abort_i | input | 1 | Repeated START or bus loss pulse |
| wp_i | input | 1 | Hardware write protect, high blocks writes |
| busy_o | output | 1 | Programming lockout; the slave must not acknowledge |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| ptr_o | output | ADDR_W | Shared word address pointer |

## Verification
The bench drives every input two nanoseconds after a rising edge, so each input is sampled at the next edge. All state-held results are compared at the falling edge that follows that sample.
- The pointer loads and `busy_o` appear one edge after the byte or STOP that causes them.
- The first array write is due WRITE_CYCLES edges after the STOP edge, and then one slot per edge.
- The pointer moves and `busy_o` falls at the edge WRITE_CYCLES + PAGE_BYTES after the STOP.

A behavioural model counts those edges from the same sampled inputs and is compared with all outputs every cycle. Array contents captured from the write port are also checked after the run.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        PW_IDLE,
        PW_ADDR_HI,
        PW_ADDR_LO,
        PW_DATA,
        PW_PROG,
        PW_COMMIT
    } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_slot_i,
    input  logic [7:0]       wr_data_i,
    input  logic [OFF_W-1:0] rd_slot_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_filled_o,
    output logic             any_filled_o
);
    logic [7:0]            data_w [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] fill_w;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [7:0] d_q;
        logic       f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                f_q <= 1'b0;
            end else if (clear_i) begin
                f_q <= 1'b0;
            end else if (wr_en_i && wr_slot_i == OFF_W'(g)) begin
                d_q <= wr_data_i;
                f_q <= 1'b1;
            end
        end
        assign data_w[g] = d_q;
        assign fill_w[g] = f_q;
    end

    assign rd_data_o    = data_w[rd_slot_i];
    assign rd_filled_o  = fill_w[rd_slot_i];
    assign any_filled_o = |fill_w;

    // R2
    slot_set_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |=> any_filled_o);
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int WRITE_CYCLES = 600000,
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOAD_V;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R4
    timer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_V);
    // R4
    timer_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pw_addr_ptr.sv
module pw_addr_ptr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              ld_commit_i,
    input  logic [ADDR_W-1:0] commit_addr_i,
    output logic [ADDR_W-1:0] ptr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (ld_commit_i)
            ptr_o <= commit_addr_i;
        else if (ld_start_i)
            ptr_o <= start_addr_i;
    end

    // R1
    one_load_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_start_i && ld_commit_i));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import pw_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              stop_i,
    input  logic              abort_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - 8;
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);

    pw_state_e state_q, state_d;

    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  last_q;
    logic [OFF_W-1:0]  slot_q;

    logic              byte_ok;
    logic [ADDR_W-1:0] start_addr_w;
    logic [ADDR_W-1:0] commit_addr_w;

    logic buf_we, buf_clear, buf_filled, buf_any;
    logic [7:0] buf_rd;
    logic tmr_load, tmr_run, tmr_done;
    logic ptr_ld_start, ptr_ld_commit;

    assign byte_ok       = byte_vld_i && !abort_i && !stop_i;
    assign start_addr_w  = {hi_q, byte_i};
    assign commit_addr_w = base_q + {{PG_W{1'b0}}, last_q} + {{(ADDR_W-1){1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PW_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:
                if (txn_begin_i) state_d = PW_ADDR_HI;
            PW_ADDR_HI:
                if (abort_i || stop_i) state_d = PW_IDLE;
                else if (byte_vld_i)   state_d = PW_ADDR_LO;
            PW_ADDR_LO:
                if (abort_i || stop_i) state_d = PW_IDLE;
                else if (byte_vld_i)   state_d = PW_DATA;
            PW_DATA:
                if (abort_i)     state_d = PW_IDLE;
                else if (stop_i) state_d = (buf_any && !wp_i) ? PW_PROG : PW_IDLE;
            PW_PROG:
                if (tmr_done) state_d = PW_COMMIT;
            PW_COMMIT:
                if (slot_q == LAST_SLOT) state_d = PW_IDLE;
            default:
                state_d = PW_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        busy_o        = 1'b0;
        mem_we_o      = 1'b0;
        buf_we        = 1'b0;
        buf_clear     = 1'b0;
        tmr_load      = 1'b0;
        tmr_run       = 1'b0;
        ptr_ld_start  = 1'b0;
        ptr_ld_commit = 1'b0;
        unique case (state_q)
            PW_IDLE:    buf_clear = 1'b1;
            PW_ADDR_HI: ;
            PW_ADDR_LO: ptr_ld_start = byte_ok;
            PW_DATA: begin
                buf_we   = byte_ok;
                tmr_load = !abort_i && stop_i && buf_any && !wp_i;
            end
            PW_PROG: begin
                busy_o  = 1'b1;
                tmr_run = 1'b1;
            end
            PW_COMMIT: begin
                busy_o        = 1'b1;
                mem_we_o      = buf_filled;
                ptr_ld_commit = (slot_q == LAST_SLOT);
            end
            default: ;
        endcase
    end

    // address and slot registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            off_q  <= '0;
            last_q <= '0;
            slot_q <= '0;
        end else begin
            if (state_q == PW_ADDR_HI && byte_ok)
                hi_q <= byte_i[HI_W-1:0];
            if (ptr_ld_start) begin
                base_q <= {start_addr_w[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                off_q  <= start_addr_w[OFF_W-1:0];
            end
            if (buf_we) begin
                last_q <= off_q;
                off_q  <= off_q + 1'b1;
            end
            if (state_q == PW_PROG)
                slot_q <= '0;
            else if (state_q == PW_COMMIT)
                slot_q <= slot_q + 1'b1;
        end
    end

    pw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (buf_clear),
        .wr_en_i      (buf_we),
        .wr_slot_i    (off_q),
        .wr_data_i    (byte_i),
        .rd_slot_i    (slot_q),
        .rd_data_o    (buf_rd),
        .rd_filled_o  (buf_filled),
        .any_filled_o (buf_any)
    );

    pw_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (tmr_run),
        .done_o (tmr_done)
    );

    pw_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_start_i    (ptr_ld_start),
        .start_addr_i  (start_addr_w),
        .ld_commit_i   (ptr_ld_commit),
        .commit_addr_i (commit_addr_w),
        .ptr_o         (ptr_o)
    );

    assign mem_addr_o  = base_q | {{PG_W{1'b0}}, slot_q};
    assign mem_wdata_o = buf_rd;

    // R3
    write_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
    // R3
    commit_stays_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
            (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));
    // R4
    busy_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));
    // R6
    busy_needs_wp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(wp_i));
    // R5
    ptr_frozen_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ptr_o));
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
    localparam int AW   = 13;
    localparam int PAGE = 32;
    localparam int WC   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_begin = 1'b0, byte_vld = 1'b0, stop_p = 1'b0, abort_p = 1'b0, wp = 1'b0;
    logic [7:0] byte_d = '0;
    logic busy, mem_we;
    logic [AW-1:0] mem_addr, ptr;
    logic [7:0] mem_wdata;

    always #5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC)) i_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .txn_begin_i(txn_begin), .byte_vld_i(byte_vld),
        .byte_i(byte_d), .stop_i(stop_p), .abort_i(abort_p), .wp_i(wp),
        .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .ptr_o(ptr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model
    int m_ph, m_hi, m_base, m_off, m_last, m_ptr, m_t;
    bit m_busy;
    int m_buf[PAGE];
    bit m_mask[PAGE];

    function automatic bit m_any();
        for (int i = 0; i < PAGE; i++) if (m_mask[i]) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_hi = 0; m_base = 0; m_off = 0; m_last = 0; m_ptr = 0;
            m_busy = 0; m_t = 0;
            for (int i = 0; i < PAGE; i++) m_mask[i] = 0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == WC + PAGE) begin
                m_busy = 0;
                m_ptr = (m_base + m_last + 1) % (1 << AW);
                for (int i = 0; i < PAGE; i++) m_mask[i] = 0;
            end
        end else begin
            case (m_ph)
                0: if (txn_begin) m_ph = 1;
                1: if (abort_p || stop_p) m_ph = 0;
                   else if (byte_vld) begin m_hi = byte_d & ((1 << (AW - 8)) - 1); m_ph = 2; end
                2: if (abort_p || stop_p) m_ph = 0;
                   else if (byte_vld) begin
                       m_ptr = m_hi * 256 + byte_d;
                       m_base = m_ptr - (m_ptr % PAGE);
                       m_off = m_ptr % PAGE;
                       for (int i = 0; i < PAGE; i++) m_mask[i] = 0;
                       m_ph = 3;
                   end
                3: if (abort_p) m_ph = 0;
                   else if (stop_p) begin
                       if (m_any() && !wp) begin m_busy = 1; m_t = 0; end
                       m_ph = 0;
                   end else if (byte_vld) begin
                       m_buf[m_off] = byte_d;
                       m_mask[m_off] = 1;
                       m_last = m_off;
                       m_off = (m_off + 1) % PAGE;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_we;
            int slot;
            exp_we = 0;
            slot = m_t - WC;
            if (m_busy && m_t >= WC && slot < PAGE) exp_we = m_mask[slot];
            check(busy == m_busy, "R4/R5/R6/R7/R9 busy", int'(busy), int'(m_busy));
            check(mem_we == exp_we, "R3 mem_we", int'(mem_we), int'(exp_we));
            if (exp_we) begin
                check(mem_addr == AW'(m_base + slot), "R3 mem_addr", int'(mem_addr), m_base + slot);
                check(mem_wdata == 8'(m_buf[slot]), "R2 mem_wdata", int'(mem_wdata), m_buf[slot]);
            end
            check(ptr == AW'(m_ptr), "R1/R8/R11 ptr", int'(ptr), m_ptr);
        end
    end

    int dmem[int];
    always @(posedge clk) if (rst_n && mem_we) dmem[int'(mem_addr)] = int'(mem_wdata);

    task automatic drive1(input bit b, input bit v, input logic [7:0] d, input bit s, input bit a);
        @(posedge clk); #2;
        txn_begin = b; byte_vld = v; byte_d = d; stop_p = s; abort_p = a;
        @(posedge clk); #2;
        txn_begin = 0; byte_vld = 0; byte_d = '0; stop_p = 0; abort_p = 0;
    endtask

    task automatic start_addr(input int a);
        drive1(1, 0, 8'h00, 0, 0);
        drive1(0, 1, 8'(a >> 8), 0, 0);
        drive1(0, 1, 8'(a), 0, 0);
    endtask

    task automatic settle();
        repeat (WC + PAGE + 4) @(posedge clk);
    endtask

    function automatic int rd(input int a);
        return dmem.exists(a) ? dmem[a] : -1;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && mem_we == 0 && ptr == '0, "R10 reset", int'(ptr), 0);

        // R1 R2 R3 R8: plain three-byte write
        start_addr(16'h0123);
        drive1(0, 1, 8'hA1, 0, 0);
        drive1(0, 1, 8'hA2, 0, 0);
        drive1(0, 1, 8'hA3, 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        settle();
        check(rd(16'h0125) == 8'hA3, "R3 array 0x125", rd(16'h0125), 8'hA3);
        check(ptr == 13'h0126, "R8 ptr after commit", int'(ptr), 16'h0126);

        // R2: wrap inside page
        start_addr(16'h0A3E);
        for (int k = 0; k < 5; k++) drive1(0, 1, 8'hB0 + 8'(k), 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        settle();
        check(rd(16'h0A20) == 8'hB2, "R2 wrap slot 0", rd(16'h0A20), 8'hB2);
        check(rd(16'h0A40) == -1, "R2 no spill to next page", rd(16'h0A40), -1);
        check(ptr == 13'h0A23, "R8 ptr after wrap", int'(ptr), 16'h0A23);

        // R2: overflow replaces earliest slots
        start_addr(16'h0040);
        for (int k = 0; k < 34; k++) drive1(0, 1, 8'(k), 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        settle();
        check(rd(16'h0040) == 32, "R2 overwrite slot 0", rd(16'h0040), 32);
        check(rd(16'h0042) == 2, "R2 slot 2 kept", rd(16'h0042), 2);
        check(ptr == 13'h0042, "R8 ptr after overflow", int'(ptr), 16'h0042);

        // R6: write protect at STOP
        start_addr(16'h0300);
        drive1(0, 1, 8'h55, 0, 0);
        wp = 1'b1;
        drive1(0, 0, 8'h00, 1, 0);
        wp = 1'b0;
        settle();
        check(rd(16'h0300) == -1, "R6 protected no write", rd(16'h0300), -1);
        check(ptr == 13'h0300, "R6 ptr at start", int'(ptr), 16'h0300);

        // R7: abort discards
        start_addr(16'h0400);
        drive1(0, 1, 8'h66, 0, 0);
        drive1(0, 0, 8'h00, 0, 1);
        settle();
        check(rd(16'h0400) == -1, "R7 abort no write", rd(16'h0400), -1);
        check(ptr == 13'h0400, "R7 ptr kept", int'(ptr), 16'h0400);

        // R9: address only
        start_addr(16'h0777);
        drive1(0, 0, 8'h00, 1, 0);
        settle();
        check(ptr == 13'h0777, "R9 address-only ptr", int'(ptr), 16'h0777);

        // R11: stop after first address byte
        drive1(1, 0, 8'h00, 0, 0);
        drive1(0, 1, 8'h05, 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        settle();
        check(ptr == 13'h0777, "R11 ptr unchanged", int'(ptr), 16'h0777);

        // R5 and R8 top-of-array: traffic during busy is ignored
        start_addr(16'h1FFF);
        drive1(0, 1, 8'hC7, 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        start_addr(16'h0500);
        drive1(0, 1, 8'h77, 0, 0);
        drive1(0, 0, 8'h00, 1, 0);
        drive1(0, 0, 8'h00, 0, 1);
        settle();
        check(rd(16'h1FFF) == 8'hC7, "R3 top byte", rd(16'h1FFF), 8'hC7);
        check(rd(16'h0500) == -1, "R5 ignored while busy", rd(16'h0500), -1);
        check(ptr == 13'h0000, "R8 ptr rollover", int'(ptr), 0);

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule